// File: doc/BRIEF.md
# Two-Level Lookahead Adder/Subtractor with Logic Unit

This block is a 16-bit integer datapath slice that adds, subtracts and applies the four bitwise operations to two operands. The arithmetic path is split into 4-bit slices. Each slice computes its internal carries straight from its own generate and propagate terms. It also reports a slice-level generate and propagate. A second lookahead stage turns those slice terms and the incoming carry into the carry that enters each slice. No carry travels serially from one slice to the next.

Subtraction inverts the second operand and injects a carry of one into the least significant bit. The same adder then produces a minus b. A selector picks either the arithmetic result or one of the bitwise results. The block reports carry-out and signed overflow as flags only. It also derives zero and negative flags from the selected result. All outputs are registered once, so a result appears on the first rising clock edge after its inputs.

Top module: `alu_cla16`

## Requirements
- R1: With op code 0 (add), one cycle later result equals (a + b) mod 2^16 and carry-out equals bit 16 of the unsigned 17-bit sum.
- R2: With op code 1 (subtract), one cycle later result equals (a - b) mod 2^16 and carry-out equals bit 16 of a + (NOT b) + 1. That bit is 1 exactly when a >= b as unsigned numbers.
- R3: On add, overflow is 1 exactly when the two operands have the same sign bit (bit 15) and the result's sign differs from it. This is equivalent to the true signed sum lying outside [-32768, 32767].
- R4: On subtract, overflow is 1 exactly when the operands' sign bits differ and the result's sign differs from the sign of a. It is never 1 when the operand signs match.
- R5: Op codes 2, 3, 4 and 5 give a AND b, a OR b, a XOR b and NOT(a OR b) respectively. For these codes, carry-out and overflow are 0.
- R6: The zero flag is 1 exactly when the registered result is all zeros.
- R7: The negative flag always equals bit 15 of the registered result.
- R8: Op codes 6 and 7 give a result of 0 with carry-out 0 and overflow 0. The zero flag is therefore 1.
- R9: While reset is low, the result, carry-out, overflow and negative outputs are 0 and the zero flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation select (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 nor) |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| result_o | output | 16 | Selected result |
| cout_o | output | 1 | Carry out of bit 15 (arithmetic ops only) |
| ovf_o | output | 1 | Signed overflow flag (arithmetic ops only) |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Result sign bit |

## Verification
Every output is registered once, so any fault shows on the ports one cycle after the stimulus that exposes it. No hidden state carries it further. A wrong slice-level generate or propagate, or a wrong term in the second lookahead stage, corrupts only those operand pairs whose carry must cross a slice boundary. The sweep therefore crosses carry-chain corner values (all ones, the most positive and most negative numbers, and alternating patterns) with many random operands for every op code. A wrong subtract injection or overflow sign rule shows up on the corner pairs that sit at the signed limits.

// File: rtl/alu_cla_pkg.sv
package alu_cla_pkg;

    localparam int DATA_W  = 16;
    localparam int SLICE_W = 4;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_NOR = 3'd5
    } alu_op_e;

endpackage

// File: rtl/cla_slice.sv
module cla_slice #(
    parameter int SW = 4
) (
    input  logic [SW-1:0] x_i,
    input  logic [SW-1:0] y_i,
    input  logic          cin_i,
    output logic [SW-1:0] sum_o,
    output logic          gen_o,
    output logic          prop_o
);

    // carry into position (upto+1): sum of products, no serial chain
    function automatic logic look_carry(input logic [SW-1:0] g,
                                        input logic [SW-1:0] p,
                                        input logic          c0,
                                        input int            upto);
        logic acc;
        logic term;
        acc = 1'b0;
        for (int j = 0; j <= upto; j++) begin
            term = g[j];
            for (int k = j + 1; k <= upto; k++) term = term & p[k];
            acc = acc | term;
        end
        term = c0;
        for (int k = 0; k <= upto; k++) term = term & p[k];
        return acc | term;
    endfunction

    logic [SW-1:0] bit_g;
    logic [SW-1:0] bit_p;
    logic [SW-1:0] cin_vec;

    always_comb begin
        bit_g = x_i & y_i;
        bit_p = x_i ^ y_i;
        cin_vec[0] = cin_i;
        for (int i = 1; i < SW; i++) cin_vec[i] = look_carry(bit_g, bit_p, cin_i, i - 1);
        sum_o  = bit_p ^ cin_vec;
        gen_o  = look_carry(bit_g, bit_p, 1'b0, SW - 1);
        prop_o = &bit_p;
    end

endmodule

// File: rtl/cla_tree.sv
module cla_tree #(
    parameter int NS = 4
) (
    input  logic [NS-1:0] sgen_i,
    input  logic [NS-1:0] sprop_i,
    input  logic          cin_i,
    output logic [NS:0]   scarry_o
);

    function automatic logic look_carry(input logic [NS-1:0] g,
                                        input logic [NS-1:0] p,
                                        input logic          c0,
                                        input int            upto);
        logic acc;
        logic term;
        acc = 1'b0;
        for (int j = 0; j <= upto; j++) begin
            term = g[j];
            for (int k = j + 1; k <= upto; k++) term = term & p[k];
            acc = acc | term;
        end
        term = c0;
        for (int k = 0; k <= upto; k++) term = term & p[k];
        return acc | term;
    endfunction

    always_comb begin
        scarry_o[0] = cin_i;
        for (int i = 1; i <= NS; i++) scarry_o[i] = look_carry(sgen_i, sprop_i, cin_i, i - 1);
    end

endmodule

// File: rtl/bitwise_unit.sv
module bitwise_unit
    import alu_cla_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         hit_o,
    output logic [W-1:0] res_o
);

    always_comb begin
        hit_o = 1'b1;
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_NOR:  res_o = ~(a_i | b_i);
            default: begin
                res_o = '0;
                hit_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu_cla16.sv
module alu_cla16
    import alu_cla_pkg::*;
#(
    parameter int WIDTH = DATA_W,
    parameter int SW    = SLICE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] result_o,
    output logic             cout_o,
    output logic             ovf_o,
    output logic             zero_o,
    output logic             neg_o
);

    localparam int NS  = WIDTH / SW;
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] result;
        logic             cout;
        logic             ovf;
        logic             zero;
        logic             neg;
    } out_t;

    out_t out_d, out_q;

    logic             is_sub;
    logic             is_arith;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] sum;
    logic [NS-1:0]    sgen;
    logic [NS-1:0]    sprop;
    logic [NS:0]      scarry;
    logic [WIDTH-1:0] bw_res;
    logic             bw_hit;

    assign is_sub   = (op_i == OP_SUB);
    assign is_arith = (op_i == OP_ADD) || is_sub;
    assign b_eff    = b_i ^ {WIDTH{is_sub}};

    for (genvar s = 0; s < NS; s++) begin : g_slice
        cla_slice #(.SW(SW)) slice_i (
            .x_i    (a_i[s*SW +: SW]),
            .y_i    (b_eff[s*SW +: SW]),
            .cin_i  (scarry[s]),
            .sum_o  (sum[s*SW +: SW]),
            .gen_o  (sgen[s]),
            .prop_o (sprop[s])
        );
    end

    cla_tree #(.NS(NS)) tree_i (
        .sgen_i   (sgen),
        .sprop_i  (sprop),
        .cin_i    (is_sub),
        .scarry_o (scarry)
    );

    bitwise_unit #(.W(WIDTH)) bw_i (
        .op_i  (op_i),
        .a_i   (a_i),
        .b_i   (b_i),
        .hit_o (bw_hit),
        .res_o (bw_res)
    );

    always_comb begin
        out_d = '0;
        if (is_arith) begin
            out_d.result = sum;
            out_d.cout   = scarry[NS];
            out_d.ovf    = (a_i[MSB] == b_eff[MSB]) && (sum[MSB] != a_i[MSB]);
        end else if (bw_hit) begin
            out_d.result = bw_res;
        end
        out_d.zero = (out_d.result == '0);
        out_d.neg  = out_d.result[MSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q      <= '0;
            out_q.zero <= 1'b1;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o = out_q.result;
    assign cout_o   = out_q.cout;
    assign ovf_o    = out_q.ovf;
    assign zero_o   = out_q.zero;
    assign neg_o    = out_q.neg;

endmodule

// File: rtl/alu_cla16_chk.sv
module alu_cla16_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       op_i,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [WIDTH-1:0] result_o,
    input logic             cout_o,
    input logic             ovf_o,
    input logic             zero_o,
    input logic             neg_o
);

    localparam int MSB = WIDTH - 1;

    logic past_ok_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    assert_add_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(op_i) == 3'd0) |-> (result_o == WIDTH'($past(a_i) + $past(b_i))));

    assert_sub_diff_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(op_i) == 3'd1) |-> (result_o == WIDTH'($past(a_i) - $past(b_i))));

    assert_add_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(op_i) == 3'd0) |->
        (ovf_o == (($past(a_i[MSB]) == $past(b_i[MSB])) && (result_o[MSB] != $past(a_i[MSB])))));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(op_i) == 3'd1 && $past(a_i[MSB]) == $past(b_i[MSB])) |-> !ovf_o);

    assert_logic_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(op_i) >= 3'd2) |-> (!cout_o && !ovf_o));

    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o == (result_o == '0));

    assert_neg_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        neg_o == result_o[MSB]);

    assert_unused_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(op_i) >= 3'd6) |-> (result_o == '0 && zero_o));

endmodule

bind alu_cla16 alu_cla16_chk #(.WIDTH(WIDTH)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .result_o (result_o),
    .cout_o   (cout_o),
    .ovf_o    (ovf_o),
    .zero_o   (zero_o),
    .neg_o    (neg_o)
);

// File: tb/alu_cla16_tb_top.sv
module alu_cla16_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = '0;
    logic [15:0] a_i = '0;
    logic [15:0] b_i = '0;
    logic [15:0] result_o;
    logic        cout_o, ovf_o, zero_o, neg_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alu_cla16 dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .result_o(result_o), .cout_o(cout_o), .ovf_o(ovf_o),
        .zero_o(zero_o), .neg_o(neg_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic apply(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s17;
        logic [15:0] er;
        logic        ec, eo;
        int          sv;
        string       rr, ro;
        @(negedge clk);
        op_i = op; a_i = a; b_i = b;
        ec = 1'b0; eo = 1'b0; er = '0; rr = "R8"; ro = "R8";
        case (op)
            3'd0: begin
                s17 = {1'b0, a} + {1'b0, b};
                er = s17[15:0]; ec = s17[16];
                sv = int'($signed(a)) + int'($signed(b));
                eo = (sv > 32767) || (sv < -32768);
                rr = "R1"; ro = "R3";
            end
            3'd1: begin
                s17 = {1'b0, a} + {1'b0, ~b} + 17'd1;
                er = s17[15:0]; ec = s17[16];
                sv = int'($signed(a)) - int'($signed(b));
                eo = (sv > 32767) || (sv < -32768);
                rr = "R2"; ro = "R4";
            end
            3'd2: begin er = a & b;    rr = "R5"; ro = "R5"; end
            3'd3: begin er = a | b;    rr = "R5"; ro = "R5"; end
            3'd4: begin er = a ^ b;    rr = "R5"; ro = "R5"; end
            3'd5: begin er = ~(a | b); rr = "R5"; ro = "R5"; end
            default: ;
        endcase
        @(negedge clk);
        chk(rr, "result", int'(result_o), int'(er));
        chk(rr, "cout", int'(cout_o), int'(ec));
        chk(ro, "ovf", int'(ovf_o), int'(eo));
        chk("R6", "zero", int'(zero_o), int'(er == 16'h0));
        chk("R7", "neg", int'(neg_o), int'(er[15]));
    endtask

    initial begin
        logic [15:0] corner [8];
        corner[0] = 16'h0000; corner[1] = 16'h0001; corner[2] = 16'h7FFF;
        corner[3] = 16'h8000; corner[4] = 16'hFFFF; corner[5] = 16'h8001;
        corner[6] = 16'h5555; corner[7] = 16'hAAAA;

        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9", "result", int'(result_o), 0);
        chk("R9", "cout", int'(cout_o), 0);
        chk("R9", "ovf", int'(ovf_o), 0);
        chk("R9", "neg", int'(neg_o), 0);
        chk("R9", "zero", int'(zero_o), 1);
        rst_n = 1'b1;

        // carry crossing every slice boundary: R1, R2
        apply(3'd0, 16'h000F, 16'h0001);
        apply(3'd0, 16'h00FF, 16'h0001);
        apply(3'd0, 16'h0FFF, 16'h0001);
        apply(3'd0, 16'hFFFF, 16'h0001);
        apply(3'd1, 16'h0000, 16'h0001);
        apply(3'd1, 16'h1000, 16'h0001);
        // signed limits: R3, R4
        apply(3'd0, 16'h7FFF, 16'h0001);
        apply(3'd0, 16'h8000, 16'hFFFF);
        apply(3'd1, 16'h8000, 16'h0001);
        apply(3'd1, 16'h7FFF, 16'hFFFF);
        apply(3'd1, 16'h8000, 16'h8000);

        // corner cross-product for every op code (R1..R8)
        for (int op = 0; op < 8; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    apply(3'(op), corner[i], corner[j]);

        // random sweep for every op code
        for (int op = 0; op < 8; op++)
            for (int n = 0; n < 1500; n++)
                apply(3'(op), 16'($urandom), 16'($urandom));

        done = 1'b1;
        finish_run();
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule